// File: doc/BRIEF.md
# Non-Maskable Interrupt Request Logic

This block turns an asynchronous, rising-edge interrupt pin into a request for the processor sequencer. The pin passes through a flip-flop synchronizer, and an edge detector then raises a sticky request. The sequencer takes the request only on a cycle that it marks as an instruction boundary. In the cycle after the take, the block presents a fixed vector index for one cycle. If the maskable interrupt enable is currently set, the block also commands the sequencer to clear it in that same cycle.

No mask affects the request. While the request is pending or being issued, the block raises an inhibit toward the maskable interrupt controller, so the non-maskable source always wins. The block keeps no in-service state. Once the sequencer acknowledges the take, the running handler does not affect the maskable sources. A new rising edge on the pin, arriving during or after the handoff, raises a fresh request.

The control is a four-state machine:
- IDLE: nothing pending.
- ARMED: the request is presented.
- ISSUE: the one-cycle vector and enable-clear output.
- AWAIT: waiting for the acknowledge.

Its transitions are:
- IDLE to ARMED on a detected edge.
- ARMED to ISSUE on a boundary strobe.
- ISSUE to AWAIT when there is no acknowledge.
- ISSUE or AWAIT to IDLE on an acknowledge when no new edge has been seen.
- ISSUE or AWAIT to ARMED on an acknowledge when an edge was seen, or arrives in the acknowledge cycle.

Top module: `nmi_req_ctrl`

## Requirements
- R1: Only a low-to-high pin transition raises a request. With the default two synchronizer stages, `nmi_req` rises after the third rising clock edge at which the pin is sampled high (SYNC_STAGES+1 edges). A level held high yields exactly one request.
- R2: Once raised, `nmi_req` stays high until it is taken. An acknowledge, or a missing boundary strobe, does not clear it.
- R3: A request is taken only at a rising edge where both `nmi_req` and `instr_bound` are high. In the next cycle `vec_vld` is 1, `vec_sel` equals NMI_VEC (default 2), and `nmi_req` is 0.
- R4: `vec_vld` is high for exactly one cycle per take. `vec_sel` is 0 whenever `vec_vld` is 0.
- R5: `ie_clr` is 1 exactly in the `vec_vld` cycle when `mask_ie` is 1, and 0 otherwise. `mask_ie` has no effect on raising or taking the request.
- R6: `mint_block` is 1 while `nmi_req` or `vec_vld` is 1. It is 0 once the take has been issued, even while the handler awaits acknowledge.
- R7: A pin pulse high for a single clock period is always captured.
- R8: An edge seen after a take, including one in the same cycle as `seq_ack`, makes `nmi_req` high in the cycle after the acknowledge. It is not presented before that acknowledge.
- R9: Several edges while a request is pending, including in the taking cycle, merge into one request.
- R10: While reset is held, `nmi_req`, `vec_vld`, `ie_clr` and `mint_block` are 0 and `vec_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_pin | input | 1 | Asynchronous interrupt pin, rising-edge sensitive |
| instr_bound | input | 1 | Instruction-boundary strobe from the sequencer |
| seq_ack | input | 1 | Sequencer acknowledge that the take is complete |
| mask_ie | input | 1 | Current maskable interrupt enable flag |
| nmi_req | output | 1 | Pending request to the sequencer |
| vec_vld | output | 1 | One-cycle strobe qualifying `vec_sel` |
| vec_sel | output | VEC_W | Vector index, NMI_VEC during `vec_vld`, else 0 |
| ie_clr | output | 1 | Command to clear the maskable enable flag |
| mint_block | output | 1 | Inhibit toward the maskable interrupt controller |

## Verification
The bench sweeps pulse width, boundary delay and the enable flag. A design that dropped single-cycle pulses, or took the request without a boundary strobe, would lose the request or issue the vector too early. It would also fail if it re-triggered on a held level, or let an acknowledge clear a request that was never taken. The bench lines up a synchronized edge exactly with the acknowledge cycle, where a careless clear would swallow the new request. It also sends edges during the wait for acknowledge, which a design with in-service tracking would block. Repeated edges while a request is pending must not produce a duplicate vector issue.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_ISSUE = 2'd2,
        ST_AWAIT = 2'd3
    } nmi_state_e;
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= d_async;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/nmi_edge.sv
module nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/nmi_fsm.sv
module nmi_fsm
    import nmi_pkg::*;
#(
    parameter int          VEC_W   = 8,
    parameter logic [VEC_W-1:0] NMI_VEC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             instr_bound,
    input  logic             seq_ack,
    input  logic             mask_ie,
    output logic             nmi_req,
    output logic             vec_vld,
    output logic [VEC_W-1:0] vec_sel,
    output logic             ie_clr,
    output logic             mint_block
);
    nmi_state_e st, st_nxt;
    logic       relatch, relatch_nxt;
    logic       in_take;

    assign in_take = (st == ST_ISSUE) || (st == ST_AWAIT);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            relatch <= 1'b0;
        end else begin
            st      <= st_nxt;
            relatch <= relatch_nxt;
        end
    end

    // next state
    always_comb begin
        st_nxt      = st;
        relatch_nxt = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (rise) st_nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (instr_bound) st_nxt = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (seq_ack) st_nxt = rise ? ST_ARMED : ST_IDLE;
                else         st_nxt = ST_AWAIT;
            end
            ST_AWAIT: begin
                if (seq_ack) st_nxt = (relatch || rise) ? ST_ARMED : ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
        if (in_take && !seq_ack) relatch_nxt = relatch | rise;
    end

    // outputs
    always_comb begin
        nmi_req    = (st == ST_ARMED);
        vec_vld    = (st == ST_ISSUE);
        vec_sel    = (st == ST_ISSUE) ? NMI_VEC : '0;
        ie_clr     = (st == ST_ISSUE) && mask_ie;
        mint_block = (st == ST_ARMED) || (st == ST_ISSUE);
    end
endmodule

// File: rtl/nmi_req_ctrl.sv
module nmi_req_ctrl #(
    parameter int               SYNC_STAGES = 2,
    parameter int               VEC_W       = 8,
    parameter logic [VEC_W-1:0] NMI_VEC     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_pin,
    input  logic             instr_bound,
    input  logic             seq_ack,
    input  logic             mask_ie,
    output logic             nmi_req,
    output logic             vec_vld,
    output logic [VEC_W-1:0] vec_sel,
    output logic             ie_clr,
    output logic             mint_block
);
    logic pin_sync;
    logic pin_rise;

    nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (nmi_pin),
        .q_sync  (pin_sync)
    );

    nmi_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (pin_sync),
        .rise  (pin_rise)
    );

    nmi_fsm #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise        (pin_rise),
        .instr_bound (instr_bound),
        .seq_ack     (seq_ack),
        .mask_ie     (mask_ie),
        .nmi_req     (nmi_req),
        .vec_vld     (vec_vld),
        .vec_sel     (vec_sel),
        .ie_clr      (ie_clr),
        .mint_block  (mint_block)
    );
endmodule

// File: rtl/nmi_req_chk.sv
module nmi_req_chk #(
    parameter int               VEC_W   = 8,
    parameter logic [VEC_W-1:0] NMI_VEC = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             instr_bound,
    input logic             mask_ie,
    input logic             nmi_req,
    input logic             vec_vld,
    input logic [VEC_W-1:0] vec_sel,
    input logic             ie_clr,
    input logic             mint_block
);
    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !instr_bound) |=> nmi_req); // R2
    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_vld) |-> $past(nmi_req && instr_bound)); // R3
    AST_VEC_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld |-> (vec_sel == NMI_VEC)); // R3
    AST_VEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld |=> !vec_vld); // R4
    AST_VEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_vld |-> (vec_sel == '0)); // R4
    AST_IE_CLR_ONLY_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        ie_clr |-> (vec_vld && mask_ie)); // R5
    AST_IE_CLR_WHEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_vld && mask_ie) |-> ie_clr); // R5
    AST_BLOCK_WHEN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req || vec_vld) |-> mint_block); // R6
    AST_REQ_NOT_DURING_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld |-> !nmi_req); // R3
endmodule

bind nmi_req_ctrl nmi_req_chk #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_bound (instr_bound),
    .mask_ie     (mask_ie),
    .nmi_req     (nmi_req),
    .vec_vld     (vec_vld),
    .vec_sel     (vec_sel),
    .ie_clr      (ie_clr),
    .mint_block  (mint_block)
);

// File: tb/tb_nmi_req_ctrl.sv
module tb_nmi_req_ctrl;
    localparam logic [7:0] EXP_VEC = 8'd2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi_pin = 1'b0;
    logic       instr_bound = 1'b0;
    logic       seq_ack = 1'b0;
    logic       mask_ie = 1'b0;
    logic       nmi_req, vec_vld, ie_clr, mint_block;
    logic [7:0] vec_sel;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    nmi_req_ctrl dut (
        .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .instr_bound(instr_bound),
        .seq_ack(seq_ack), .mask_ie(mask_ie), .nmi_req(nmi_req), .vec_vld(vec_vld),
        .vec_sel(vec_sel), .ie_clr(ie_clr), .mint_block(mint_block)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: act=%0d exp=<100000 cycles", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic ck(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(int w);
        nmi_pin = 1'b1;
        fork
            begin
                repeat (w) @(negedge clk);
                nmi_pin = 1'b0;
            end
        join_none
    endtask

    task automatic take_and_ack();
        instr_bound = 1'b1; step(); instr_bound = 1'b0;
        step();
        seq_ack = 1'b1; step(); seq_ack = 1'b0;
    endtask

    task automatic run_take(int w, int d, logic ie);
        mask_ie = ie;
        pulse(w);
        step(); step();
        ck("R1 not before sync latency", int'(nmi_req), 0);
        step();
        ck((w == 1) ? "R7 single-cycle pulse caught" : "R1 request raised", int'(nmi_req), 1);
        ck("R6 block while pending", int'(mint_block), 1);
        for (int k = 0; k < d; k++) begin
            if (k == 0) seq_ack = 1'b1;
            step();
            seq_ack = 1'b0;
            ck("R2 request held", int'(nmi_req), 1);
        end
        instr_bound = 1'b1; step(); instr_bound = 1'b0;
        ck("R3 vec_vld on take", int'(vec_vld), 1);
        ck("R3 vec_sel value", int'(vec_sel), int'(EXP_VEC));
        ck("R3 req cleared on take", int'(nmi_req), 0);
        ck("R5 ie_clr follows mask_ie", int'(ie_clr), int'(ie));
        ck("R6 block during issue", int'(mint_block), 1);
        step();
        ck("R4 vec_vld one cycle", int'(vec_vld), 0);
        ck("R4 vec_sel zero", int'(vec_sel), 0);
        ck("R5 ie_clr one cycle", int'(ie_clr), 0);
        ck("R6 no block while handler runs", int'(mint_block), 0);
        repeat (w) step();
        seq_ack = 1'b1; step(); seq_ack = 1'b0;
        step(); step();
        ck("R1 no duplicate request", int'(nmi_req), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        ck("R10 reset nmi_req", int'(nmi_req), 0);
        ck("R10 reset vec_vld", int'(vec_vld), 0);
        ck("R10 reset vec_sel", int'(vec_sel), 0);
        ck("R10 reset ie_clr", int'(ie_clr), 0);
        ck("R10 reset mint_block", int'(mint_block), 0);
        rst_n = 1'b1;
        step(); step();

        // sweep pulse width, boundary delay, enable flag
        for (int w = 1; w <= 4; w++)
            for (int d = 0; d <= 3; d++)
                for (int ie = 0; ie <= 1; ie++)
                    run_take(w, d, logic'(ie));

        // long level: one request only
        run_take(25, 1, 1'b1);
        repeat (25) step();
        ck("R1 held level no retrigger", int'(nmi_req), 0);

        // re-entry while awaiting acknowledge (R8)
        pulse(1); repeat (3) step();
        instr_bound = 1'b1; step(); instr_bound = 1'b0;
        step();
        pulse(1); repeat (5) step();
        ck("R8 not presented before ack", int'(nmi_req), 0);
        seq_ack = 1'b1; step(); seq_ack = 1'b0;
        ck("R8 re-entry after ack", int'(nmi_req), 1);
        take_and_ack();
        step();

        // edge in the same cycle as acknowledge (R8)
        pulse(1); repeat (3) step();
        instr_bound = 1'b1; step(); instr_bound = 1'b0;
        step();
        pulse(1);
        step(); step();
        seq_ack = 1'b1; step(); seq_ack = 1'b0;
        ck("R8 edge with ack stays pending", int'(nmi_req), 1);
        take_and_ack();
        repeat (3) step();
        ck("R8 cleaned up", int'(nmi_req), 0);

        // multiple edges merge (R9)
        pulse(1); repeat (3) step();
        pulse(1); repeat (4) step();
        pulse(1); repeat (4) step();
        ck("R9 still one pending", int'(nmi_req), 1);
        take_and_ack();
        repeat (6) step();
        ck("R9 merged into one take", int'(nmi_req), 0);

        // mask flag has no effect on raising (R5)
        mask_ie = 1'b0;
        pulse(2); repeat (3) step();
        ck("R5 raised with mask clear", int'(nmi_req), 1);
        take_and_ack();
        step();

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule